// File: doc/BRIEF.md
# Macro-Op Pair Fusion Detector

This block sits in the decode stage and looks at two adjacent 32-bit RV64 instruction words at a time. It checks whether the leading and following words form one of five supported pairs. The pairs are: a 32-bit constant build, a shift plus add, a PC-relative jump, an increment plus not-equal branch, and a constant-address doubleword load. When a pair matches, the block emits one macro-op descriptor and suppresses the following slot. The descriptor carries a kind code, a destination, two source registers and a merged immediate.

Fusion is an optimisation and must never change architectural results. A pair is fused only when the register dependencies make the merged operation exactly equivalent to the two instructions. Otherwise both words leave unchanged with their valid bits. The kind field is sized for a catalogue of 19 fusion kinds. Codes 1 to 5 are in use here and the rest are held back for later pairs. Every result is registered, so the outputs describe the window presented one clock earlier.

Top module: `fuse_detect`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: If either input valid bit is 0, `fuse` is 0, the descriptor outputs are 0, and both slots pass through with their own valid bits.
- R3: A `lui rd` leader (opcode 0110111) followed by `addi rd, rd, imm` (opcode 0010011, funct3 000) fuses as kind 1. `fuse_rd` is rd, both source outputs are 0, and `fuse_imm` is the sign-extended `lui` value (upper 20 bits shifted left by 12) plus the sign-extended 12-bit `addi` immediate.
- R4: `slli rd, rs, sh` (opcode 0010011, funct3 001, bits 31:26 zero) followed by `add rd, a, b` (opcode 0110011, funct3 000, funct7 0) fuses as kind 2 when exactly one of a and b equals rd. The outputs are `fuse_rd`=rd, `fuse_rs1`=rs (the shifted index), `fuse_rs2`=the other add operand, and `fuse_imm`=sh zero-extended. If both add operands equal rd, the pair does not fuse.
- R5: `auipc t` (opcode 0010111) followed by `jalr d, imm(t)` (opcode 1100111, funct3 000) fuses as kind 3 for any d, including x0. The outputs are `fuse_rd`=d, `fuse_rs1`=t, `fuse_rs2`=0, and `fuse_imm` is the sign-extended upper value plus the sign-extended `jalr` offset.
- R6: `addi rd, rs, i` followed by `bne` (opcode 1100011, funct3 001) that reads rd in either source fuses as kind 4. The outputs are `fuse_rd`=rd, `fuse_rs1`=rs, and `fuse_rs2`=the other branch operand (rd if both read it). `fuse_imm` bits 63:32 hold the sign-extended branch offset and bits 31:0 hold the sign-extended `addi` immediate.
- R7: `lui rd` followed by `ld rd, off(rd)` (opcode 0000011, funct3 011) fuses as kind 5. `fuse_rd` is rd, both source outputs are 0, and `fuse_imm` is the absolute address (upper value plus sign-extended offset).
- R8: A leader whose destination is x0 never fuses.
- R9: A pair does not fuse if the follower fails to read the leader's destination in the required source. For `addi`, `jalr` and `ld` that source is rs1; for `add` and `bne` it is either source. Kinds 1, 2 and 5 also do not fuse if the follower writes a different destination. A pair that does not fuse passes through unchanged.
- R10: When `fuse` is 1, `out_v0` is 1, `out_v1` is 0, and `fuse_kind` is one of 1 to 5. When `fuse` is 0, `fuse_kind` is 0. The kind field is 5 bits wide, and codes 6 to 31 are reserved and never emitted.
- R11: All outputs appear one clock after the inputs are sampled, and `out_instr0`/`out_instr1` carry the two input words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_v0 | input | 1 | Leading slot valid |
| in_instr0 | input | 32 | Leading instruction word |
| in_v1 | input | 1 | Following slot valid |
| in_instr1 | input | 32 | Following instruction word |
| out_v0 | output | 1 | Leading slot valid, registered |
| out_instr0 | output | 32 | Leading instruction word, registered |
| out_v1 | output | 1 | Following slot valid, cleared when fused |
| out_instr1 | output | 32 | Following instruction word, registered |
| fuse | output | 1 | Pair fused into one macro-op |
| fuse_kind | output | 5 | Fusion kind code, 0 when not fused |
| fuse_rd | output | 5 | Macro-op destination register |
| fuse_rs1 | output | 5 | Macro-op first source register |
| fuse_rs2 | output | 5 | Macro-op second source register |
| fuse_imm | output | 64 | Merged immediate of the macro-op |

## Verification
A wrong match decision shows up on the next clock in two ways: `fuse` is set while `out_v1` still follows the input, or a following instruction vanishes from a pair that should have passed. A corrupted field merge shows up in the same cycle as a wrong `fuse_imm` or a wrong register number. The most telling case is the `lui`/`addi` sum with a negative low immediate, which must borrow from the upper part. Because each window is independent and the pipeline holds only one register stage, every fault appears on the window that caused it. The bench therefore feeds windows back to back and sends dependency-breaking near misses right after matching pairs.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

    localparam int XLEN      = 64;
    localparam int ILEN      = 32;
    localparam int REG_W     = 5;
    localparam int SHAMT_W   = 6;
    localparam int NUM_KINDS = 19;
    localparam int KIND_W    = $clog2(NUM_KINDS + 1);
    localparam int HALF      = XLEN / 2;

    localparam logic [6:0] OPC_LUI    = 7'b0110111;
    localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [6:0] OPC_OP     = 7'b0110011;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;

    typedef enum logic [KIND_W-1:0] {
        FK_NONE       = KIND_W'(0),
        FK_LUI_ADDI   = KIND_W'(1),
        FK_SLLI_ADD   = KIND_W'(2),
        FK_AUIPC_JALR = KIND_W'(3),
        FK_ADDI_BNE   = KIND_W'(4),
        FK_LUI_LD     = KIND_W'(5)
    } fkind_e;

    typedef struct packed {
        logic             is_lui;
        logic             is_auipc;
        logic             is_addi;
        logic             is_slli;
        logic             is_add;
        logic             is_jalr;
        logic             is_bne;
        logic             is_ld;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [XLEN-1:0]  imm_u;
        logic [XLEN-1:0]  imm_i;
        logic [XLEN-1:0]  imm_b;
        logic [SHAMT_W-1:0] shamt;
    } slot_info_t;

    typedef struct packed {
        logic             fuse;
        fkind_e           kind;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [XLEN-1:0]  imm;
    } fuse_desc_t;

    typedef struct packed {
        logic            v0;
        logic [ILEN-1:0] i0;
        logic            v1;
        logic [ILEN-1:0] i1;
        fuse_desc_t      desc;
    } out_state_t;

endpackage

// File: rtl/fuse_slot_decode.sv
module fuse_slot_decode
    import fuse_pkg::*;
(
    input  logic [ILEN-1:0] instr,
    output slot_info_t      info
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [31:0] u_raw;
    logic [12:0] b_raw;

    always_comb begin
        opc   = instr[6:0];
        f3    = instr[14:12];
        u_raw = {instr[31:12], 12'b0};
        b_raw = {instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};

        info          = '0;
        info.is_lui   = (opc == OPC_LUI);
        info.is_auipc = (opc == OPC_AUIPC);
        info.is_addi  = (opc == OPC_OPIMM) && (f3 == 3'b000);
        info.is_slli  = (opc == OPC_OPIMM) && (f3 == 3'b001) && (instr[31:26] == 6'b0);
        info.is_add   = (opc == OPC_OP) && (f3 == 3'b000) && (instr[31:25] == 7'b0);
        info.is_jalr  = (opc == OPC_JALR) && (f3 == 3'b000);
        info.is_bne   = (opc == OPC_BRANCH) && (f3 == 3'b001);
        info.is_ld    = (opc == OPC_LOAD) && (f3 == 3'b011);
        info.rd       = instr[11:7];
        info.rs1      = instr[19:15];
        info.rs2      = instr[24:20];
        info.imm_u    = {{(XLEN-32){u_raw[31]}}, u_raw};
        info.imm_i    = {{(XLEN-12){instr[31]}}, instr[31:20]};
        info.imm_b    = {{(XLEN-13){b_raw[12]}}, b_raw};
        info.shamt    = instr[25:20];
    end
endmodule

// File: rtl/fuse_pair_match.sv
module fuse_pair_match
    import fuse_pkg::*;
(
    input  logic       lead_v,
    input  logic       fol_v,
    input  slot_info_t lead,
    input  slot_info_t fol,
    output fuse_desc_t desc
);
    logic both_v;
    logic lead_nz;
    logic same_rd;
    logic rd_on_1;
    logic rd_on_2;

    always_comb begin
        both_v  = lead_v && fol_v;
        lead_nz = (lead.rd != '0);
        same_rd = (fol.rd == lead.rd);
        rd_on_1 = (fol.rs1 == lead.rd);
        rd_on_2 = (fol.rs2 == lead.rd);

        desc = '0;
        if (both_v && lead_nz) begin
            if (lead.is_lui && fol.is_addi && rd_on_1 && same_rd) begin
                desc.fuse = 1'b1;
                desc.kind = FK_LUI_ADDI;
                desc.rd   = lead.rd;
                desc.imm  = lead.imm_u + fol.imm_i;
            end else if (lead.is_slli && fol.is_add && same_rd && (rd_on_1 ^ rd_on_2)) begin
                desc.fuse = 1'b1;
                desc.kind = FK_SLLI_ADD;
                desc.rd   = lead.rd;
                desc.rs1  = lead.rs1;
                desc.rs2  = rd_on_1 ? fol.rs2 : fol.rs1;
                desc.imm  = XLEN'(lead.shamt);
            end else if (lead.is_auipc && fol.is_jalr && rd_on_1) begin
                desc.fuse = 1'b1;
                desc.kind = FK_AUIPC_JALR;
                desc.rd   = fol.rd;
                desc.rs1  = lead.rd;
                desc.imm  = lead.imm_u + fol.imm_i;
            end else if (lead.is_addi && fol.is_bne && (rd_on_1 || rd_on_2)) begin
                desc.fuse = 1'b1;
                desc.kind = FK_ADDI_BNE;
                desc.rd   = lead.rd;
                desc.rs1  = lead.rs1;
                desc.rs2  = rd_on_1 ? fol.rs2 : fol.rs1;
                desc.imm  = {fol.imm_b[HALF-1:0], lead.imm_i[HALF-1:0]};
            end else if (lead.is_lui && fol.is_ld && rd_on_1 && same_rd) begin
                desc.fuse = 1'b1;
                desc.kind = FK_LUI_LD;
                desc.rd   = lead.rd;
                desc.imm  = lead.imm_u + fol.imm_i;
            end
        end
    end
endmodule

// File: rtl/fuse_detect.sv
module fuse_detect
    import fuse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v0,
    input  logic [ILEN-1:0]   in_instr0,
    input  logic              in_v1,
    input  logic [ILEN-1:0]   in_instr1,
    output logic              out_v0,
    output logic [ILEN-1:0]   out_instr0,
    output logic              out_v1,
    output logic [ILEN-1:0]   out_instr1,
    output logic              fuse,
    output logic [KIND_W-1:0] fuse_kind,
    output logic [REG_W-1:0]  fuse_rd,
    output logic [REG_W-1:0]  fuse_rs1,
    output logic [REG_W-1:0]  fuse_rs2,
    output logic [XLEN-1:0]   fuse_imm
);
    localparam int SLOTS = 2;

    logic [ILEN-1:0] slot_word [SLOTS];
    slot_info_t      slot_info [SLOTS];
    fuse_desc_t      desc_c;
    out_state_t      state_d;
    out_state_t      state_q;

    assign slot_word[0] = in_instr0;
    assign slot_word[1] = in_instr1;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        fuse_slot_decode i_dec (
            .instr (slot_word[s]),
            .info  (slot_info[s])
        );
    end

    fuse_pair_match i_match (
        .lead_v (in_v0),
        .fol_v  (in_v1),
        .lead   (slot_info[0]),
        .fol    (slot_info[1]),
        .desc   (desc_c)
    );

    always_comb begin
        state_d      = '0;
        state_d.v0   = in_v0;
        state_d.i0   = in_instr0;
        state_d.v1   = in_v1 && !desc_c.fuse;
        state_d.i1   = in_instr1;
        state_d.desc = desc_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_v0     = state_q.v0;
    assign out_instr0 = state_q.i0;
    assign out_v1     = state_q.v1;
    assign out_instr1 = state_q.i1;
    assign fuse       = state_q.desc.fuse;
    assign fuse_kind  = state_q.desc.kind;
    assign fuse_rd    = state_q.desc.rd;
    assign fuse_rs1   = state_q.desc.rs1;
    assign fuse_rs2   = state_q.desc.rs2;
    assign fuse_imm   = state_q.desc.imm;
endmodule

// File: rtl/fuse_detect_chk.sv
module fuse_detect_chk
    import fuse_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_v0,
    input logic [ILEN-1:0]   in_instr0,
    input logic              in_v1,
    input logic [ILEN-1:0]   in_instr1,
    input logic              out_v0,
    input logic [ILEN-1:0]   out_instr0,
    input logic              out_v1,
    input logic [ILEN-1:0]   out_instr1,
    input logic              fuse,
    input logic [KIND_W-1:0] fuse_kind,
    input logic [REG_W-1:0]  fuse_rd,
    input logic [REG_W-1:0]  fuse_rs1,
    input logic [REG_W-1:0]  fuse_rs2,
    input logic [XLEN-1:0]   fuse_imm
);
    // R10
    follower_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fuse |-> (out_v0 && !out_v1));

    // R10
    kind_catalogue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fuse_kind != '0) == fuse) && (fuse_kind <= KIND_W'(5)));

    // R8
    lead_dest_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse && fuse_kind == KIND_W'(FK_AUIPC_JALR)) |-> (fuse_rs1 != '0));

    // R2
    invalid_no_fuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_v0 || !in_v1) |=> !fuse);

    // R11
    word_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_instr0 == $past(in_instr0)) && (out_instr1 == $past(in_instr1)));

    // R3
    const_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fuse && fuse_kind == KIND_W'(FK_LUI_ADDI)) |-> (fuse_imm[11:0] == out_instr1[31:20]));
endmodule

bind fuse_detect fuse_detect_chk i_fuse_detect_chk (.*);

// File: tb/test_fuse_detect.sv
module test_fuse_detect;
    import fuse_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic            v0;
        logic [31:0]     i0;
        logic            v1;
        logic [31:0]     i1;
        logic            fz;
        int              kind;
        int              rd;
        int              rs1;
        int              rs2;
        logic [63:0]     imm;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_v0 = 1'b0, in_v1 = 1'b0;
    logic [31:0] in_instr0 = '0, in_instr1 = '0;
    logic out_v0, out_v1, fuse;
    logic [31:0] out_instr0, out_instr1;
    logic [KIND_W-1:0] fuse_kind;
    logic [REG_W-1:0] fuse_rd, fuse_rs1, fuse_rs2;
    logic [XLEN-1:0] fuse_imm;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_detect i_fuse_detect (.*);

    function automatic logic [31:0] enc_u(logic [6:0] op, int rd, logic [19:0] v);
        return {v, 5'(rd), op};
    endfunction
    function automatic logic [31:0] enc_i(logic [6:0] op, logic [2:0] f3, int rd, int rs1, logic [11:0] v);
        return {v, 5'(rs1), f3, 5'(rd), op};
    endfunction
    function automatic logic [31:0] enc_add(int rd, int a, int b);
        return {7'b0, 5'(b), 5'(a), 3'b000, 5'(rd), 7'b0110011};
    endfunction
    function automatic logic [31:0] enc_bne(int a, int b, logic [12:0] off);
        return {off[12], off[10:5], 5'(b), 5'(a), 3'b001, off[4:1], off[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] lui(int rd, logic [19:0] v);   return enc_u(7'b0110111, rd, v); endfunction
    function automatic logic [31:0] auipc(int rd, logic [19:0] v); return enc_u(7'b0010111, rd, v); endfunction
    function automatic logic [31:0] addi(int rd, int rs, logic [11:0] v); return enc_i(7'b0010011, 3'b000, rd, rs, v); endfunction
    function automatic logic [31:0] slli(int rd, int rs, int sh); return enc_i(7'b0010011, 3'b001, rd, rs, 12'(sh)); endfunction
    function automatic logic [31:0] jalr(int rd, int rs, logic [11:0] v); return enc_i(7'b1100111, 3'b000, rd, rs, v); endfunction
    function automatic logic [31:0] ld(int rd, int rs, logic [11:0] v); return enc_i(7'b0000011, 3'b011, rd, rs, v); endfunction

    task automatic send(logic v0, logic [31:0] i0, logic v1, logic [31:0] i1,
                        logic fz, int kind, int rd, int rs1, int rs2, logic [63:0] imm, string tag);
        exp_t e;
        @(negedge clk);
        in_v0 = v0; in_instr0 = i0; in_v1 = v1; in_instr1 = i1;
        e.v0 = v0; e.i0 = i0; e.v1 = v1 && !fz; e.i1 = i1;
        e.fz = fz; e.kind = kind; e.rd = rd; e.rs1 = rs1; e.rs2 = rs2; e.imm = imm; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic pass(logic v0, logic [31:0] i0, logic v1, logic [31:0] i1, string tag);
        send(v0, i0, v1, i1, 1'b0, 0, 0, 0, 0, 64'd0, tag);
    endtask

    // monitor: compares one expected item per clock, one cycle after it was driven (R11)
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (out_v0 !== e.v0 || out_instr0 !== e.i0 || out_v1 !== e.v1 || out_instr1 !== e.i1 ||
                fuse !== e.fz || fuse_kind !== KIND_W'(e.kind) || fuse_rd !== REG_W'(e.rd) ||
                fuse_rs1 !== REG_W'(e.rs1) || fuse_rs2 !== REG_W'(e.rs2) || fuse_imm !== e.imm) begin
                fails++;
                $display("FAIL %s: got v0=%b v1=%b fuse=%b kind=%0d rd=%0d rs1=%0d rs2=%0d imm=%h, expected v0=%b v1=%b fuse=%b kind=%0d rd=%0d rs1=%0d rs2=%0d imm=%h",
                         e.tag, out_v0, out_v1, fuse, fuse_kind, fuse_rd, fuse_rs1, fuse_rs2, fuse_imm,
                         e.v0, e.v1, e.fz, e.kind, e.rd, e.rs1, e.rs2, e.imm);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        in_v0 = 1'b1; in_v1 = 1'b1;
        in_instr0 = lui(5, 20'h12345); in_instr1 = addi(5, 5, 12'h678);
        repeat (3) @(posedge clk);
        @(negedge clk);
        tests++;
        if (out_v0 !== 1'b0 || out_v1 !== 1'b0 || fuse !== 1'b0 || fuse_kind !== '0 ||
            out_instr0 !== '0 || fuse_imm !== '0) begin
            fails++;
            $display("FAIL R1: got v0=%b v1=%b fuse=%b kind=%0d imm=%h, expected all zero",
                     out_v0, out_v1, fuse, fuse_kind, fuse_imm);
        end
        in_v0 = 1'b0; in_v1 = 1'b0;
        rst_n = 1'b1;

        // R3: constant build, positive, borrowing and sign-extending cases
        send(1, lui(5, 20'h12345), 1, addi(5, 5, 12'h678), 1, 1, 5, 0, 0, 64'h0000_0000_1234_5678, "R3 R10");
        send(1, lui(5, 20'h12345), 1, addi(5, 5, 12'hFFF), 1, 1, 5, 0, 0, 64'h0000_0000_1234_4FFF, "R3 borrow");
        send(1, lui(6, 20'h80000), 1, addi(6, 6, 12'h000), 1, 1, 6, 0, 0, 64'hFFFF_FFFF_8000_0000, "R3 sext");
        // R4: shifted-index add, rd on either add operand, both operands rd rejected
        send(1, slli(7, 8, 3), 1, enc_add(7, 7, 9), 1, 2, 7, 8, 9, 64'd3, "R4 rs1");
        send(1, slli(7, 8, 33), 1, enc_add(7, 9, 7), 1, 2, 7, 8, 9, 64'd33, "R4 rs2");
        pass(1, slli(7, 8, 3), 1, enc_add(7, 7, 7), "R4 both-operands");
        // R5: pc-relative jump with same and different link register
        send(1, auipc(1, 20'h00001), 1, jalr(1, 1, 12'h010), 1, 3, 1, 1, 0, 64'h1010, "R5 same");
        send(1, auipc(6, 20'h00002), 1, jalr(0, 6, 12'hFFC), 1, 3, 0, 6, 0, 64'h1FFC, "R5 x0 link");
        // R6: increment plus branch, rd in either branch source
        send(1, addi(10, 10, 12'h001), 1, enc_bne(10, 11, 13'h1FF8), 1, 4, 10, 10, 11,
             64'hFFFF_FFF8_0000_0001, "R6 rs1");
        send(1, addi(10, 12, 12'hFFE), 1, enc_bne(11, 10, 13'h0020), 1, 4, 10, 12, 11,
             64'h0000_0020_FFFF_FFFE, "R6 rs2");
        // R7: absolute-address load
        send(1, lui(12, 20'h00010), 1, ld(12, 12, 12'h008), 1, 5, 12, 0, 0, 64'h10008, "R7");
        send(1, lui(12, 20'h00010), 1, ld(12, 12, 12'hFF8), 1, 5, 12, 0, 0, 64'hFFF8, "R7 neg");
        // R8: leader writes x0
        pass(1, lui(0, 20'h12345), 1, addi(0, 0, 12'h001), "R8");
        pass(1, addi(0, 0, 12'h001), 1, enc_bne(0, 3, 13'h0010), "R8 branch");
        // R9: dependency mismatches
        pass(1, lui(5, 20'h12345), 1, addi(6, 5, 12'h001), "R9 dest differs");
        pass(1, lui(5, 20'h00010), 1, ld(5, 6, 12'h000), "R9 wrong source");
        pass(1, auipc(4, 20'h00001), 1, jalr(1, 3, 12'h000), "R9 jalr source");
        pass(1, addi(10, 10, 12'h001), 1, enc_bne(11, 12, 13'h0010), "R9 branch source");
        pass(1, enc_add(3, 4, 5), 1, enc_add(3, 3, 6), "R9 no pattern");
        // R2: invalid slots
        pass(1, lui(5, 20'h12345), 0, addi(5, 5, 12'h678), "R2 follower invalid");
        pass(0, lui(5, 20'h12345), 1, addi(5, 5, 12'h678), "R2 leader invalid");
        // R11: back-to-back fused then plain
        send(1, lui(9, 20'hABCDE), 1, addi(9, 9, 12'h123), 1, 1, 9, 0, 0, 64'hFFFF_FFFF_ABCD_E123, "R11 burst");
        pass(1, enc_add(1, 2, 3), 1, enc_add(4, 5, 6), "R11 burst plain");

        @(negedge clk);
        in_v0 = 1'b0; in_v1 = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule